// File: doc/BRIEF.md
# ADC Result Compare Monitor

This block watches the stream of conversion results that an analog-to-digital converter writes into its per-module result slots. It carries four independent compare units. Each unit follows one sample module, checks every new 12-bit result from that module against a programmed threshold, and counts results that meet the programmed condition in a row. When the run of matches is long enough, the unit raises a sticky flag that software clears by writing 1. This lets firmware watch an input voltage for a threshold crossing without reading each sample.

Unit 0 can be joined with unit 1, and unit 2 with unit 3, to form a window comparator. In that case the lower unit counts a result only when its own condition and its partner's condition both hold for that result. The partner unit keeps working on its own as well.

Each unit also shows a live status bit that tells whether the last result it compared was at or above its threshold. A single interrupt request combines the flags of all units whose interrupt is enabled.

Top module: `adc_result_monitor`

## Requirements
- R1: After reset, all flags, all compare status bits and the interrupt request are 0, and every match counter is 0.
- R2: A unit's condition bit selects its test, and results and thresholds compare as unsigned 12-bit values. With the bit at 0 a result matches when it is below the threshold. With the bit at 1 it matches when it is at or above the threshold.
- R3: A unit's flag rises on the clock edge that takes the (L+1)-th matching result in a row, where L is the unit's 4-bit match-count field. The flag is visible at the port in the cycle after that edge. The counter then starts again from zero.
- R4: A compared result that fails the condition resets the unit's match counter to zero, so the count must start again.
- R5: A unit compares a result only when it is enabled and the strobed module index equals its 5-bit module select. Any other result has no effect on its counter, flag or status bit.
- R6: With the pair bit p set (bit 0 joins units 0 and 1, bit 1 joins units 2 and 3), unit 2p counts a result only when that result meets both its own condition and unit 2p+1's condition. Unit 2p+1 keeps counting and flagging on its own.
- R7: Writing 1 to a bit of flag_clr clears that flag on the next edge. If a flag sets on the same edge as a clear, the set wins.
- R8: A unit's status bit becomes 1 when the last result it compared was at or above its threshold, and 0 when it was below. The new value appears one cycle after the compare, and the bit holds between compares.
- R9: irq is high exactly when some unit has both its flag and its interrupt enable set. It follows the flag and enable ports with no extra register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| res_valid | input | 1 | Result-write strobe, one cycle per result |
| res_mod | input | 5 | Sample module index of the result |
| res_data | input | 12 | Conversion result, unsigned |
| cfg_en | input | 4 | Per-unit compare enable |
| cfg_ie | input | 4 | Per-unit interrupt enable |
| cfg_ge | input | 4 | Per-unit condition: 0 below, 1 at or above |
| cfg_pair | input | 2 | Window pair enable: bit p joins units 2p and 2p+1 |
| cfg_sel | input | 20 | Module select, unit i at bits [5i+4:5i] |
| cfg_cnt | input | 16 | Match count L, unit i at bits [4i+3:4i] |
| cfg_thr | input | 48 | Threshold, unit i at bits [12i+11:12i] |
| flag_clr | input | 4 | Write-1-to-clear strobe per flag |
| flag | output | 4 | Sticky compare flags |
| cmp_out | output | 4 | Live at-or-above status of the last compared result |
| irq | output | 1 | Interrupt request |

## Verification
A wrong match counter cannot be seen directly. It shows up only as a flag that rises one matching result too early or too late, or fails to restart after a miss. So the bench compares every flag on every cycle against a model of each unit, using runs of matches that are shorter than, equal to and longer than L+1. A stale or corrupted status bit is visible at cmp_out in the cycle after the next compare. A fault in the window pairing shows as flag 0 or flag 2 rising for results outside the window at the next edge. Because irq has no register of its own, a masking fault shows in the same cycle as the flag.

// File: rtl/adc_cmp_pkg.sv
package adc_cmp_pkg;
    typedef enum logic {
        COND_BELOW    = 1'b0,
        COND_AT_ABOVE = 1'b1
    } cmp_cond_e;
endpackage

// File: rtl/adc_cmp_eval.sv
module adc_cmp_eval
    import adc_cmp_pkg::*;
#(
    parameter int RES_W = 12,
    parameter int SEL_W = 5
) (
    input  logic             res_valid,
    input  logic [SEL_W-1:0] res_mod,
    input  logic [RES_W-1:0] res_data,
    input  logic             en,
    input  logic [SEL_W-1:0] sel,
    input  logic [RES_W-1:0] thr,
    input  logic             ge_mode,
    output logic             take,
    output logic             cond,
    output logic             at_or_above
);
    always_comb begin
        take        = res_valid && en && (res_mod == sel);
        at_or_above = (res_data >= thr);
        if (cmp_cond_e'(ge_mode) == COND_AT_ABOVE) cond = at_or_above;
        else                                       cond = !at_or_above;
    end
endmodule

// File: rtl/adc_cmp_track.sv
module adc_cmp_track #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             take,
    input  logic             hit,
    input  logic             at_or_above,
    input  logic [CNT_W-1:0] lim,
    input  logic             clr,
    output logic             flag,
    output logic             status
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             flag;
        logic             stat;
    } track_t;

    track_t st_d, st_q;
    logic   fire;

    always_comb begin
        st_d = st_q;
        fire = take && hit && (st_q.cnt >= lim);
        if (take) begin
            st_d.stat = at_or_above;
            if (!hit || fire) st_d.cnt = '0;
            else              st_d.cnt = st_q.cnt + 1'b1;
        end
        if (fire)     st_d.flag = 1'b1;
        else if (clr) st_d.flag = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag   = st_q.flag;
    assign status = st_q.stat;

    // R3
    flag_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.flag) |-> $past(take && hit));

    // R4
    miss_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !hit) |=> (st_q.cnt == '0));

    // R7
    clear_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !(take && hit)) |=> !st_q.flag);

    // R8
    status_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !take |=> $stable(st_q.stat));
endmodule

// File: rtl/adc_result_monitor.sv
module adc_result_monitor #(
    parameter int N_UNITS = 4,
    parameter int RES_W   = 12,
    parameter int SEL_W   = 5,
    parameter int CNT_W   = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     res_valid,
    input  logic [SEL_W-1:0]         res_mod,
    input  logic [RES_W-1:0]         res_data,
    input  logic [N_UNITS-1:0]       cfg_en,
    input  logic [N_UNITS-1:0]       cfg_ie,
    input  logic [N_UNITS-1:0]       cfg_ge,
    input  logic [N_UNITS/2-1:0]     cfg_pair,
    input  logic [N_UNITS*SEL_W-1:0] cfg_sel,
    input  logic [N_UNITS*CNT_W-1:0] cfg_cnt,
    input  logic [N_UNITS*RES_W-1:0] cfg_thr,
    input  logic [N_UNITS-1:0]       flag_clr,
    output logic [N_UNITS-1:0]       flag,
    output logic [N_UNITS-1:0]       cmp_out,
    output logic                     irq
);
    localparam int N_PAIRS = N_UNITS / 2;

    logic [N_UNITS-1:0] take;
    logic [N_UNITS-1:0] cond;
    logic [N_UNITS-1:0] above;
    logic [N_UNITS-1:0] hit;

    for (genvar i = 0; i < N_UNITS; i++) begin : g_unit
        adc_cmp_eval #(
            .RES_W (RES_W),
            .SEL_W (SEL_W)
        ) u_eval (
            .res_valid   (res_valid),
            .res_mod     (res_mod),
            .res_data    (res_data),
            .en          (cfg_en[i]),
            .sel         (cfg_sel[i*SEL_W +: SEL_W]),
            .thr         (cfg_thr[i*RES_W +: RES_W]),
            .ge_mode     (cfg_ge[i]),
            .take        (take[i]),
            .cond        (cond[i]),
            .at_or_above (above[i])
        );

        if ((i % 2 == 0) && (i / 2 < N_PAIRS)) begin : g_pair
            assign hit[i] = cfg_pair[i/2] ? (cond[i] && cond[i+1]) : cond[i];
        end else begin : g_solo
            assign hit[i] = cond[i];
        end

        adc_cmp_track #(
            .CNT_W (CNT_W)
        ) u_track (
            .clk         (clk),
            .rst_n       (rst_n),
            .take        (take[i]),
            .hit         (hit[i]),
            .at_or_above (above[i]),
            .lim         (cfg_cnt[i*CNT_W +: CNT_W]),
            .clr         (flag_clr[i]),
            .flag        (flag[i]),
            .status      (cmp_out[i])
        );
    end

    assign irq = |(flag & cfg_ie);

    // R9
    irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_ie == '0) |-> !irq);
endmodule

// File: tb/adc_result_monitor_test.sv
module adc_result_monitor_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        res_valid;
    logic [4:0]  res_mod;
    logic [11:0] res_data;
    logic [3:0]  cfg_en, cfg_ie, cfg_ge, flag_clr;
    logic [1:0]  cfg_pair;
    logic [19:0] cfg_sel;
    logic [15:0] cfg_cnt;
    logic [47:0] cfg_thr;
    logic [3:0]  flag, cmp_out;
    logic        irq;

    int n_tests = 0;
    int n_fail  = 0;

    int         m_cnt [4];
    logic [3:0] m_flag;
    logic [3:0] m_out;

    always #4 clk = ~clk;

    adc_result_monitor uut (
        .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_mod(res_mod),
        .res_data(res_data), .cfg_en(cfg_en), .cfg_ie(cfg_ie), .cfg_ge(cfg_ge),
        .cfg_pair(cfg_pair), .cfg_sel(cfg_sel), .cfg_cnt(cfg_cnt),
        .cfg_thr(cfg_thr), .flag_clr(flag_clr), .flag(flag),
        .cmp_out(cmp_out), .irq(irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic cond_f(input int i, input logic [11:0] d);
        logic ab;
        ab = (d >= cfg_thr[i*12 +: 12]);
        return cfg_ge[i] ? ab : !ab;
    endfunction

    task automatic model_step();
        logic [3:0] fl;
        logic [3:0] ou;
        fl = m_flag;
        ou = m_out;
        for (int i = 0; i < 4; i++) begin
            logic tk, ht, fire;
            tk = res_valid && cfg_en[i] && (res_mod == cfg_sel[i*5 +: 5]);
            ht = cond_f(i, res_data);
            if ((i % 2 == 0) && cfg_pair[i/2]) ht = ht && cond_f(i + 1, res_data);
            fire = tk && ht && (m_cnt[i] >= int'(cfg_cnt[i*4 +: 4]));
            if (tk) begin
                ou[i] = (res_data >= cfg_thr[i*12 +: 12]);
                if (!ht || fire) m_cnt[i] = 0;
                else             m_cnt[i] = m_cnt[i] + 1;
            end
            if (fire)             fl[i] = 1'b1;
            else if (flag_clr[i]) fl[i] = 1'b0;
        end
        m_flag = fl;
        m_out  = ou;
    endtask

    task automatic cycle(input string tag);
        @(posedge clk);
        model_step();
        @(negedge clk);
        check({tag, " R3 flag"}, 32'(flag), 32'(m_flag));
        check({tag, " R8 cmp_out"}, 32'(cmp_out), 32'(m_out));
        check({tag, " R9 irq"}, 32'(irq), 32'(|(m_flag & cfg_ie)));
    endtask

    task automatic send(input logic [4:0] m, input logic [11:0] d, input logic [3:0] c, input string tag);
        res_valid = 1'b1; res_mod = m; res_data = d; flag_clr = c;
        cycle(tag);
        res_valid = 1'b0; flag_clr = '0;
    endtask

    task automatic set_unit(input int i, input logic e, input logic g, input logic [4:0] s,
                            input logic [3:0] l, input logic [11:0] t);
        cfg_en[i] = e; cfg_ge[i] = g;
        cfg_sel[i*5 +: 5] = s; cfg_cnt[i*4 +: 4] = l; cfg_thr[i*12 +: 12] = t;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] seed_v;
        seed_v = $urandom(32'd9137);
        rst_n = 1'b0; res_valid = 0; res_mod = 0; res_data = 0;
        cfg_en = 0; cfg_ie = 0; cfg_ge = 0; cfg_pair = 0; cfg_sel = 0;
        cfg_cnt = 0; cfg_thr = 0; flag_clr = 0;
        for (int i = 0; i < 4; i++) m_cnt[i] = 0;
        m_flag = 0; m_out = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        check("R1 reset flag", 32'(flag), 0);
        check("R1 reset cmp_out", 32'(cmp_out), 0);
        check("R1 reset irq", 32'(irq), 0);

        // R2 below condition, R3 L=2 needs three matches
        set_unit(0, 1, 0, 5'd1, 4'd2, 12'd100);
        send(5'd1, 12'd50, 0, "R2");
        send(5'd1, 12'd99, 0, "R2");
        check("R3 two matches no flag", 32'(flag[0]), 0);
        send(5'd1, 12'd0, 0, "R3");
        check("R3 third match sets flag", 32'(flag[0]), 1);
        check("R8 below gives 0", 32'(cmp_out[0]), 0);
        check("R9 masked irq", 32'(irq), 0);
        cfg_ie[0] = 1'b1;
        #1;
        check("R9 irq follows enable", 32'(irq), 1);

        // R7 clear, then set wins over clear
        send(5'd0, 12'd0, 4'b0001, "R7");
        check("R7 clear flag", 32'(flag[0]), 0);
        cfg_cnt[3:0] = 4'd0;
        send(5'd1, 12'd5, 4'b0001, "R7");
        check("R7 set wins", 32'(flag[0]), 1);
        send(5'd0, 12'd0, 4'b0001, "R7");

        // R4 miss restarts count
        cfg_cnt[3:0] = 4'd2;
        send(5'd1, 12'd1, 0, "R4");
        send(5'd1, 12'd1, 0, "R4");
        send(5'd1, 12'd100, 0, "R4");
        check("R8 at threshold gives 1", 32'(cmp_out[0]), 1);
        send(5'd1, 12'd1, 0, "R4");
        send(5'd1, 12'd1, 0, "R4");
        check("R4 restarted no flag", 32'(flag[0]), 0);
        send(5'd1, 12'd1, 0, "R4");
        check("R4 flag after full run", 32'(flag[0]), 1);
        send(5'd0, 12'd0, 4'b0001, "R7");

        // R5 other module and disabled unit ignored
        cfg_cnt[3:0] = 4'd0;
        send(5'd2, 12'd1, 0, "R5");
        check("R5 other module ignored", 32'(flag[0]), 0);
        check("R5 status untouched", 32'(cmp_out[0]), 0);
        cfg_en[0] = 1'b0;
        send(5'd1, 12'd1, 0, "R5");
        check("R5 disabled ignored", 32'(flag[0]), 0);
        cfg_en[0] = 1'b1;

        // R6 window 20 <= x < 100 on pair 0
        set_unit(1, 1, 1, 5'd1, 4'd0, 12'd20);
        cfg_pair[0] = 1'b1;
        send(5'd1, 12'd10, 0, "R6");
        check("R6 below window", 32'(flag[0]), 0);
        send(5'd1, 12'd50, 0, "R6");
        check("R6 inside window", 32'(flag[0]), 1);
        check("R6 partner own flag", 32'(flag[1]), 1);
        check("R2 at-or-above condition", 32'(cmp_out[1]), 1);
        send(5'd0, 12'd0, 4'b1111, "R7");

        // random phase
        for (int k = 0; k < 4000; k++) begin
            if (k % 60 == 0) begin
                for (int i = 0; i < 4; i++)
                    set_unit(i, 1'($urandom), 1'($urandom), 5'($urandom % 3),
                             4'($urandom % 4), 12'($urandom));
                cfg_ie = 4'($urandom);
                cfg_pair = 2'($urandom);
            end
            res_valid = ($urandom % 4) != 0;
            res_mod   = 5'($urandom % 4);
            res_data  = 12'($urandom);
            flag_clr  = (($urandom % 8) == 0) ? 4'($urandom) : 4'd0;
            cycle("RND");
        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule